// File: doc/BRIEF.md
# Sampler Result FIFO with Fill Status

This block sits between the result bus of a sampling converter and the output register that drives the data pins. Each result word is 18 bits wide: 16 sample bits, a copy of the sign/MSB bit and an over-range flag. A falling edge on the conversion-busy line marks a finished conversion. A mode input selects one of two paths. In the first, results pass straight to the output register. In the second, results are queued in a 16-entry first-word-fall-through store.

In queued mode the oldest stored word is shown on the outputs without any read. Each rising edge of the read line replaces it with the next older word. Writes to a full store are dropped. A read on an empty store leaves the last word on the outputs. A two-bit fill code reports four bands: empty, low, half or more, and full. Holding the mode input at direct while the read line is low empties the store. An active-low enable floats the data outputs.

All inputs are synchronous to the single system clock. Edges on the busy line and the read line are found with registered edge detectors.

Top module: `sample_fifo_top`

## Requirements
- R1: The store holds DEPTH (default 16) words. Each word is {overflow, msb, data[15:0]}, and all three fields come back unchanged on q_ovf, q_msb and q_data.
- R2: While rst is high at a clock edge, the output word register clears to all zeros and {fill_hi, fill_lo} becomes 2'b01.
- R3: With fifo_mode high, a clock edge where conv_busy is sampled low after being sampled high at the edge before writes {res_ovf, res_msb, res_data} into the store. This happens whatever the level of rd_line.
- R4: A word written into an empty store appears on the outputs right after the write edge, with no read.
- R5: With fifo_mode high and the store not empty, a clock edge where rd_line is sampled high after being sampled low removes the head word. The next older word is shown if one remains.
- R6: {fill_hi, fill_lo} is 01 for 0 words, 00 for 1 to 7 words, 10 for 8 to 15 words and 11 for 16 words. It follows the word count one clock later.
- R7: A write that arrives while the store holds DEPTH words is discarded, and the count stays at DEPTH.
- R8: A read edge while the store is empty changes neither the outputs nor the count.
- R9: With fifo_mode low, every finished conversion is loaded straight into the output register. Read and write edges leave the store contents and count untouched.
- R10: fifo_mode low together with rd_line low at a clock edge empties the store.
- R11: With oe_n high, q_data, q_msb and q_ovf are high impedance. With oe_n low they carry the output word register.
- R12: A write and a read at the same edge, with 1 to 15 words stored, leave the count unchanged. When one word was stored, the new word is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_busy | input | 1 | High during a conversion; its falling edge marks a result |
| res_data | input | 16 | Conversion result bits |
| res_msb | input | 1 | Sign/MSB copy of the result |
| res_ovf | input | 1 | Over-range flag of the result |
| fifo_mode | input | 1 | 1 = results queued in the store, 0 = direct path |
| rd_line | input | 1 | Rising edge advances the head; low with direct mode empties the store |
| oe_n | input | 1 | Active-low output enable for the data outputs |
| q_data | output | 16 | Output word data bits, high impedance when disabled |
| q_msb | output | 1 | Output word MSB copy, high impedance when disabled |
| q_ovf | output | 1 | Output word overflow flag, high impedance when disabled |
| fill_hi | output | 1 | Upper bit of the fill code |
| fill_lo | output | 1 | Lower bit of the fill code |

## Verification
The bench builds the block with the default depth of 16. Eighteen conversions therefore cross every fill band: the 7-to-8 half-full step, the exact full point and two dropped writes. A drain follows, then reads past empty. With only 16 entries, pointer wrap-around is reached within a few hundred cycles. Simultaneous read and write edges at a single stored word are also reached. So are a direct-mode excursion with the store retained and a clear through mode plus read-low.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned RES_W = 16;

    typedef struct packed {
        logic             ovf;
        logic             msb;
        logic [RES_W-1:0] data;
    } sample_t;

    typedef enum logic [1:0] {
        FILL_LOW   = 2'b00,
        FILL_EMPTY = 2'b01,
        FILL_HALF  = 2'b10,
        FILL_FULL  = 2'b11
    } fill_code_t;

    function automatic fill_code_t encode_fill(input int unsigned words,
                                               input int unsigned depth);
        if (words == 0)
            return FILL_EMPTY;
        else if (words >= depth)
            return FILL_FULL;
        else if (words >= depth / 2)
            return FILL_HALF;
        else
            return FILL_LOW;
    endfunction

    function automatic sample_t pack_sample(input logic [RES_W-1:0] data,
                                            input logic msb,
                                            input logic ovf);
        sample_t s;
        s.ovf  = ovf;
        s.msb  = msb;
        s.data = data;
        return s;
    endfunction

endpackage

// File: rtl/sfifo_edge.sv
module sfifo_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else
            level_q <= level;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = level & ~level_q;
        end else begin : g_fall
            assign pulse = ~level & level_q;
        end
    endgenerate

    // R3 / R5: a detected edge lasts a single clock
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fifo_en,
    input  logic                         clr,
    input  logic                         wr,
    input  logic                         rd,
    input  sample_t                      wdata,
    output logic                         wr_ok,
    output logic                         rd_ok,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output sample_t                      next_word
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    sample_t        mem [DEPTH];
    logic [PW-1:0]  rd_ptr;
    logic [PW-1:0]  wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign wr_ok     = fifo_en & wr & (count != FULL_CNT);
    assign rd_ok     = fifo_en & rd & (count != '0);
    assign next_word = mem[bump(rd_ptr)];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok)
                wr_ptr <= bump(wr_ptr);
            if (rd_ok)
                rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wr_ptr] <= wdata;
    end

    // R7: the count never passes the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R7: a lone write on a full store is dropped
    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && wr && !rd && count == FULL_CNT) |=> count == FULL_CNT);

    // R10: mode low with read low empties the store
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

    // R9: direct mode leaves the count alone
    a_r9_direct_keep: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !clr) |=> $stable(count));

    // R12: accepted write plus read keeps the count
    a_r12_both: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && rd_ok) |=> $stable(count));

endmodule

// File: rtl/sfifo_outreg.sv
module sfifo_outreg
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fifo_en,
    input  logic                         conv_done,
    input  sample_t                      wdata,
    input  logic                         wr_ok,
    input  logic                         rd_ok,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    input  sample_t                      next_word,
    output sample_t                      q
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!fifo_en) begin
            if (conv_done)
                q <= wdata;
        end else if (rd_ok) begin
            if (count > ONE)
                q <= next_word;
            else if (wr_ok)
                q <= wdata;
        end else if (wr_ok && count == '0) begin
            q <= wdata;
        end
    end

    // R4: first word into an empty store is shown at once
    a_r4_first_word: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && wr_ok && !rd_ok && count == '0) |=> q == $past(wdata));

    // R8: a read edge on an empty store with no write holds the word
    a_r8_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !wr_ok && count == '0) |=> $stable(q));

endmodule

// File: rtl/sfifo_status.sv
module sfifo_status
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    output fill_code_t                   code
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    always_ff @(posedge clk) begin
        if (rst)
            code <= FILL_EMPTY;
        else
            code <= encode_fill(32'(count), DEPTH);
    end

    // R6: empty count reads back as the empty code one clock later
    a_r6_empty_code: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> code == FILL_EMPTY);

    // R6: full count reads back as the full code one clock later
    a_r6_full_code: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |=> code == FILL_FULL);

endmodule

// File: rtl/sample_fifo_top.sv
module sample_fifo_top
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_busy,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_msb,
    input  logic             res_ovf,
    input  logic             fifo_mode,
    input  logic             rd_line,
    input  logic             oe_n,
    output logic [RES_W-1:0] q_data,
    output logic             q_msb,
    output logic             q_ovf,
    output logic             fill_hi,
    output logic             fill_lo
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic             conv_done;
    logic             rd_edge;
    logic             wr_ok;
    logic             rd_ok;
    logic             store_clr;
    logic [CW-1:0]    count;
    sample_t          wdata;
    sample_t          next_word;
    sample_t          word_q;
    fill_code_t       code;

    assign wdata     = pack_sample(res_data, res_msb, res_ovf);
    assign store_clr = ~fifo_mode & ~rd_line;

    sfifo_edge #(.RISING(1'b0)) u_conv_edge (
        .clk   (clk),
        .rst   (rst),
        .level (conv_busy),
        .pulse (conv_done)
    );

    sfifo_edge #(.RISING(1'b1)) u_read_edge (
        .clk   (clk),
        .rst   (rst),
        .level (rd_line),
        .pulse (rd_edge)
    );

    sfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_mode),
        .clr       (store_clr),
        .wr        (conv_done),
        .rd        (rd_edge),
        .wdata     (wdata),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .count     (count),
        .next_word (next_word)
    );

    sfifo_outreg #(.DEPTH(DEPTH)) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_mode),
        .conv_done (conv_done),
        .wdata     (wdata),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .count     (count),
        .next_word (next_word),
        .q         (word_q)
    );

    sfifo_status #(.DEPTH(DEPTH)) u_status (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .code  (code)
    );

    assign q_data  = oe_n ? {RES_W{1'bz}} : word_q.data;
    assign q_msb   = oe_n ? 1'bz : word_q.msb;
    assign q_ovf   = oe_n ? 1'bz : word_q.ovf;
    assign fill_hi = code[1];
    assign fill_lo = code[0];

    // R9: direct mode loads a finished conversion into the output word
    a_r9_direct_load: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && conv_done) |=> word_q == $past(wdata));

endmodule

// File: tb/sample_fifo_top_bench.sv
module sample_fifo_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        conv_busy;
    logic [17:0] din;
    logic        fifo_mode;
    logic        rd_line;
    logic        oe_n;
    wire  [15:0] q_data;
    wire         q_msb;
    wire         q_ovf;
    wire         fill_hi;
    wire         fill_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string phase = "R2 reset";

    logic [17:0] q_m[$];
    logic [17:0] out_m;
    logic [1:0]  stat_m;
    logic        prev_conv;
    logic        prev_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_fifo_top #(.DEPTH(DEPTH)) u_sample_fifo_top (
        .clk       (clk),
        .rst       (rst),
        .conv_busy (conv_busy),
        .res_data  (din[15:0]),
        .res_msb   (din[16]),
        .res_ovf   (din[17]),
        .fifo_mode (fifo_mode),
        .rd_line   (rd_line),
        .oe_n      (oe_n),
        .q_data    (q_data),
        .q_msb     (q_msb),
        .q_ovf     (q_ovf),
        .fill_hi   (fill_hi),
        .fill_lo   (fill_lo)
    );

    function automatic logic [1:0] fill_of(input int n);
        if (n == 0)          return 2'b01;
        else if (n >= DEPTH) return 2'b11;
        else if (n >= DEPTH/2) return 2'b10;
        else                 return 2'b00;
    endfunction

    task automatic model_edge();
        bit wr, rd, rd_eff, wr_eff;
        int old_n;
        if (rst) begin
            q_m.delete();
            out_m = '0; stat_m = 2'b01;
            prev_conv = 1'b0; prev_rd = 1'b0;
            return;
        end
        wr = prev_conv && !conv_busy;
        rd = rd_line && !prev_rd;
        old_n = q_m.size();
        stat_m = fill_of(old_n);
        if (fifo_mode) begin
            rd_eff = rd && (old_n > 0);
            wr_eff = wr && (old_n < DEPTH);
            if (rd_eff) void'(q_m.pop_front());
            if (wr_eff) q_m.push_back(din);
            if (rd_eff) begin
                if (q_m.size() > 0) out_m = q_m[0];
            end else if (wr_eff && old_n == 0) begin
                out_m = din;
            end
        end else begin
            if (wr) out_m = din;
            if (!rd_line) q_m.delete();
        end
        prev_conv = conv_busy;
        prev_rd   = rd_line;
    endtask

    task automatic compare();
        logic [17:0] got, exp;
        got = {q_ovf, q_msb, q_data};
        exp = oe_n ? 18'bz : out_m;
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: output word got %h expected %h", phase, got, exp);
        end
        n_checks++;
        if ({fill_hi, fill_lo} !== stat_m) begin
            n_fail++;
            $display("FAIL %s: fill code got %b expected %b", phase, {fill_hi, fill_lo}, stat_m);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic convert(input logic [17:0] w);
        din = w; conv_busy = 1'b1;
        step(); step();
        conv_busy = 1'b0;
        step(); step();
    endtask

    task automatic read_pulse();
        rd_line = 1'b0; step();
        rd_line = 1'b1; step();
    endtask

    function automatic logic [17:0] pat(input int i);
        logic [15:0] d;
        d = 16'hA5A5 ^ (16'(i) * 16'h1111);
        return {1'(i), ~1'(i >> 1), d};
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        rst = 1'b1; conv_busy = 1'b0; din = '0;
        fifo_mode = 1'b0; rd_line = 1'b0; oe_n = 1'b0;
        phase = "R2 reset";
        repeat (3) step();
        rst = 1'b0;
        step();

        phase = "R1 R3 R4 R6 fill";
        fifo_mode = 1'b1; rd_line = 1'b1;
        step();
        for (int i = 0; i < 8; i++) convert(pat(i));
        phase = "R3 R6 fill with read low";
        rd_line = 1'b0;
        for (int i = 8; i < 16; i++) convert(pat(i));
        step();

        phase = "R7 full drop";
        convert(18'h3FFFF);
        convert(18'h00001);

        phase = "R5 R6 drain";
        for (int i = 0; i < 15; i++) read_pulse();
        phase = "R8 read past empty";
        for (int i = 0; i < 3; i++) read_pulse();

        phase = "R12 write with read";
        convert(pat(40));
        for (int k = 0; k < 3; k++) begin
            din = pat(50 + k); conv_busy = 1'b1;
            step(); step();
            rd_line = 1'b0; step();
            conv_busy = 1'b0; rd_line = 1'b1; step();
            step();
        end
        convert(pat(60)); convert(pat(61));
        for (int k = 0; k < 2; k++) begin
            din = pat(70 + k); conv_busy = 1'b1;
            step(); step();
            rd_line = 1'b0; step();
            conv_busy = 1'b0; rd_line = 1'b1; step();
            step();
        end

        phase = "R9 direct mode";
        fifo_mode = 1'b0;
        for (int i = 0; i < 3; i++) convert(pat(80 + i));
        step();
        phase = "R9 store kept";
        fifo_mode = 1'b1;
        for (int i = 0; i < 4; i++) read_pulse();

        phase = "R10 clear";
        convert(pat(90)); convert(pat(91));
        fifo_mode = 1'b0; rd_line = 1'b0;
        step(); step();
        fifo_mode = 1'b1; rd_line = 1'b1;
        step(); step();
        convert(pat(92));
        read_pulse();

        phase = "R11 output enable";
        oe_n = 1'b1;
        step(); step();
        convert(pat(93));
        oe_n = 1'b0;
        step(); step();

        phase = "R1 wrap";
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 11; i++) convert(pat(100 + r * 11 + i));
            for (int i = 0; i < 11; i++) read_pulse();
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got no end expected an end");
            summary();
            $finish;
        end
    end

endmodule